// File: doc/BRIEF.md
# Vector-Extension Access Trap Router

This block decides whether software running at the current exception level may touch the scalable-vector register state. When it may not, the block picks the exception level that takes the trap. Its inputs are the current level (0 to 3), the secure-state flag, a flag saying whether the top level (EL3) runs in 64-bit state, and three control words: the EL1 coprocessor access control word, the EL2 trap word and the EL3 trap word. The result is a 2-bit target level. A value of 0 means the access is allowed.

Four checks run in a fixed priority order: the vector enable field, then the floating-point enable field, then the EL2 trap bits, then the EL3 trap bits. The first check that traps sets the result. The decision is available combinationally on its own output. It is also captured into an output register one clock after a request strobe, and a trap-valid flag is registered with it. An instruction pipeline can sample that registered pair synchronously.

Top module: `vec_trap_router`

## Requirements
- R1: The vector enable field sits at bits [17:16] of the access control word. A value of 0 or 2 traps accesses from EL0 and EL1. A value of 1 traps only EL0 accesses. A value of 3 traps nothing. An access at EL2 or EL3 is never trapped by this field.
- R2: When either enable field traps, the target is 3 if the secure flag is set and the EL3-is-64-bit flag is clear. Otherwise the target is 1.
- R3: The floating-point enable field at bits [21:20] of the same word uses the encoding of R1 and the target rule of R2. It is checked after the vector field.
- R4: The target is 2 when all three of these hold: the current level is 2 or below, bit 8 or bit 10 of the EL2 trap word is set, and the core is not in secure state.
- R5: The target is 3 when bit 8 of the EL3 trap word is clear or bit 10 of that word is set.
- R6: The first trapping check in the order vector field, FP field, EL2 word, EL3 word decides the result. If no check traps, the result is 0.
- R7: The registered target `tgt_o` takes the combinational decision on the clock edge where `req_i` is high. On every other edge it holds its value.
- R8: `trap_o` is high exactly when the registered target is nonzero.
- R9: While reset is asserted, `tgt_o` and `trap_o` are 0.
- R10: Bits of the three control words other than [17:16], [21:20], 8 and 10 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Capture the current decision into the output register |
| cur_el_i | input | 2 | Current exception level |
| secure_i | input | 1 | Core is in secure state |
| el3_aa64_i | input | 1 | EL3 runs in 64-bit state |
| acc_ctl_i | input | CTRL_W | EL1 access control word |
| hyp_trap_i | input | CTRL_W | EL2 trap word |
| mon_trap_i | input | CTRL_W | EL3 trap word |
| comb_tgt_o | output | 2 | Combinational target level, 0 = allowed |
| tgt_o | output | 2 | Registered target level |
| trap_o | output | 1 | Registered trap-valid flag |

## Verification
The assertions assume that the inputs are stable at the clock edge where `req_i` is high. They also assume that `cur_el_i` is a legal level and that the core is never at EL3 in non-secure state with a trapping EL2 word. The last assumption does not matter to the result, because the level check already blocks the EL2 rule at EL3. The stimulus changes inputs only on the falling edge and raises `req_i` for exactly one cycle per decision. It sweeps all 4096 combinations of level, both enable fields, the four trap bits and the two state flags. It then repeats part of the sweep with the unused control bits set, and with `req_i` low, to show that the output register holds.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
  typedef logic [1:0] el_t;

  localparam el_t EL_NONE = 2'd0;
  localparam el_t EL_ONE  = 2'd1;
  localparam el_t EL_TWO  = 2'd2;
  localparam el_t EL_MON  = 2'd3;

  localparam int VEC_EN_LSB  = 16;
  localparam int FP_EN_LSB   = 20;
  localparam int TRAP_VEC_IX = 8;
  localparam int TRAP_FP_IX  = 10;
  localparam int N_CHECKS    = 4;
endpackage

// File: rtl/vtr_field_chk.sv
module vtr_field_chk
  import vtr_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int LSB    = 16
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  el_t               cur_el_i,
  input  logic              secure_i,
  input  logic              el3_aa64_i,
  output logic              hit_o,
  output el_t               tgt_o
);
  logic [1:0] fld;

  always_comb begin
    fld = ctrl_i[LSB +: 2];
    unique case (fld)
      2'b11:   hit_o = 1'b0;
      2'b01:   hit_o = (cur_el_i == EL_NONE);
      default: hit_o = (cur_el_i <= EL_ONE);
    endcase
    tgt_o = (secure_i && !el3_aa64_i) ? EL_MON : EL_ONE;
  end
endmodule

// File: rtl/vtr_trapreg_chk.sv
module vtr_trapreg_chk
  import vtr_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter bit IS_MON = 1'b0
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  el_t               cur_el_i,
  input  logic              secure_i,
  output logic              hit_o,
  output el_t               tgt_o
);
  logic vec_b, fp_b;

  assign vec_b = ctrl_i[TRAP_VEC_IX];
  assign fp_b  = ctrl_i[TRAP_FP_IX];

  generate
    if (IS_MON) begin : g_mon
      assign hit_o = !vec_b || fp_b;
      assign tgt_o = EL_MON;
    end else begin : g_hyp
      logic sec_below;
      assign sec_below = secure_i && (cur_el_i != EL_MON);
      assign hit_o = (cur_el_i <= EL_TWO) && (vec_b || fp_b) && !sec_below;
      assign tgt_o = EL_TWO;
    end
  endgenerate
endmodule

// File: rtl/vtr_prio.sv
module vtr_prio
  import vtr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]      hit_i,
  input  el_t  [N-1:0]      tgt_i,
  output el_t               sel_o
);
  always_comb begin
    sel_o = EL_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) sel_o = tgt_i[i];
    end
  end
endmodule

// File: rtl/vec_trap_router.sv
module vec_trap_router
  import vtr_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        cur_el_i,
  input  logic              secure_i,
  input  logic              el3_aa64_i,
  input  logic [CTRL_W-1:0] acc_ctl_i,
  input  logic [CTRL_W-1:0] hyp_trap_i,
  input  logic [CTRL_W-1:0] mon_trap_i,
  output logic [1:0]        comb_tgt_o,
  output logic [1:0]        tgt_o,
  output logic              trap_o
);
  logic [N_CHECKS-1:0] hit;
  el_t  [N_CHECKS-1:0] tgt;
  el_t                 dec;

  vtr_field_chk #(.CTRL_W(CTRL_W), .LSB(VEC_EN_LSB)) u_vec (
    .ctrl_i(acc_ctl_i), .cur_el_i(cur_el_i), .secure_i(secure_i),
    .el3_aa64_i(el3_aa64_i), .hit_o(hit[0]), .tgt_o(tgt[0])
  );

  vtr_field_chk #(.CTRL_W(CTRL_W), .LSB(FP_EN_LSB)) u_fp (
    .ctrl_i(acc_ctl_i), .cur_el_i(cur_el_i), .secure_i(secure_i),
    .el3_aa64_i(el3_aa64_i), .hit_o(hit[1]), .tgt_o(tgt[1])
  );

  vtr_trapreg_chk #(.CTRL_W(CTRL_W), .IS_MON(1'b0)) u_hyp (
    .ctrl_i(hyp_trap_i), .cur_el_i(cur_el_i), .secure_i(secure_i),
    .hit_o(hit[2]), .tgt_o(tgt[2])
  );

  vtr_trapreg_chk #(.CTRL_W(CTRL_W), .IS_MON(1'b1)) u_mon (
    .ctrl_i(mon_trap_i), .cur_el_i(cur_el_i), .secure_i(secure_i),
    .hit_o(hit[3]), .tgt_o(tgt[3])
  );

  vtr_prio #(.N(N_CHECKS)) u_prio (
    .hit_i(hit), .tgt_i(tgt), .sel_o(dec)
  );

  assign comb_tgt_o = dec;

  el_t  tgt_q, tgt_d;
  logic trap_q, trap_d;

  always_comb begin
    tgt_d  = tgt_q;
    trap_d = trap_q;
    if (req_i) begin
      tgt_d  = dec;
      trap_d = (dec != EL_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= EL_NONE;
      trap_q <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      trap_q <= trap_d;
    end
  end

  assign tgt_o  = tgt_q;
  assign trap_o = trap_q;

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (tgt_o == $past(comb_tgt_o)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(tgt_o));

  a_r8_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o == (tgt_o != EL_NONE));

  a_r4_no_hyp_secure: assert property (@(posedge clk) disable iff (!rst_n)
    secure_i |-> (comb_tgt_o != EL_TWO));

  a_r1_mon_level_only_mon: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el_i == EL_MON) |-> (comb_tgt_o == EL_NONE || comb_tgt_o == EL_MON));

  a_r5_mon_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_trap_i[TRAP_VEC_IX] || mon_trap_i[TRAP_FP_IX]) |-> (comb_tgt_o != EL_NONE));

  a_r6_all_open: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ctl_i[VEC_EN_LSB +: 2] == 2'b11 && acc_ctl_i[FP_EN_LSB +: 2] == 2'b11 &&
     !hyp_trap_i[TRAP_VEC_IX] && !hyp_trap_i[TRAP_FP_IX] &&
     mon_trap_i[TRAP_VEC_IX] && !mon_trap_i[TRAP_FP_IX]) |-> (comb_tgt_o == EL_NONE));
endmodule

// File: tb/vec_trap_router_tb.sv
`timescale 1ns/1ps
module vec_trap_router_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_i = 1'b0;
  logic [1:0]   cur_el_i = '0;
  logic         secure_i = 1'b0;
  logic         el3_aa64_i = 1'b0;
  logic [W-1:0] acc_ctl_i = '0;
  logic [W-1:0] hyp_trap_i = '0;
  logic [W-1:0] mon_trap_i = '0;
  logic [1:0]   comb_tgt_o, tgt_o;
  logic         trap_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_trap_router #(.CTRL_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cur_el_i(cur_el_i),
    .secure_i(secure_i), .el3_aa64_i(el3_aa64_i), .acc_ctl_i(acc_ctl_i),
    .hyp_trap_i(hyp_trap_i), .mon_trap_i(mon_trap_i),
    .comb_tgt_o(comb_tgt_o), .tgt_o(tgt_o), .trap_o(trap_o)
  );

  // Reference: value of a 2-bit enable field decides lowest level still allowed
  function automatic int field_traps(int fld, int el);
    int lim;
    lim = (fld == 3) ? -1 : ((fld == 1) ? 0 : 1);
    return (el <= lim) ? 1 : 0;
  endfunction

  function automatic int ref_tgt(int el, int sec, int aa64, int vf, int ff,
                                 int h8, int h10, int m8, int m10);
    int fld_tgt;
    fld_tgt = (sec == 1 && aa64 == 0) ? 3 : 1;
    if (field_traps(vf, el) == 1) return fld_tgt;
    if (field_traps(ff, el) == 1) return fld_tgt;
    if (el < 3 && (h8 + h10) > 0 && sec == 0) return 2;
    if (m8 == 0 || m10 == 1) return 3;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(int idx, logic [W-1:0] noise);
    logic [W-1:0] a, h, m;
    a = noise; h = noise; m = noise;
    a[17:16] = idx[3:2];
    a[21:20] = idx[5:4];
    h[8] = idx[6]; h[10] = idx[7];
    m[8] = idx[8]; m[10] = idx[9];
    cur_el_i   = idx[1:0];
    secure_i   = idx[10];
    el3_aa64_i = idx[11];
    acc_ctl_i  = a; hyp_trap_i = h; mon_trap_i = m;
  endtask

  function automatic int ref_of(int idx);
    return ref_tgt(idx & 3, (idx >> 10) & 1, (idx >> 11) & 1, (idx >> 2) & 3,
                   (idx >> 4) & 3, (idx >> 6) & 1, (idx >> 7) & 1,
                   (idx >> 8) & 1, (idx >> 9) & 1);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 tgt in reset", tgt_o, 0);
    check("R9 trap in reset", trap_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 tgt after reset", tgt_o, 0);

    // R1 R2 R3 R4 R5 R6 R7 R8: full sweep
    for (int idx = 0; idx < 4096; idx++) begin
      apply(idx, '0);
      req_i = 1'b1;
      exp = ref_of(idx);
      #1;
      check("R6 comb decision", comb_tgt_o, exp);
      @(negedge clk);
      req_i = 1'b0;
      check("R7 registered target", tgt_o, exp);
      check("R8 trap flag", trap_o, (exp != 0) ? 1 : 0);
    end

    // R10: unused control bits set
    for (int idx = 0; idx < 4096; idx += 7) begin
      apply(idx, 32'hFFCC_FAFF ^ (idx << 12));
      req_i = 1'b1;
      exp = ref_of(idx);
      @(negedge clk);
      req_i = 1'b0;
      check("R10 unused bits ignored", tgt_o, exp);
    end

    // R7: hold while req low
    for (int idx = 1; idx < 4096; idx += 97) begin
      int held;
      apply(idx, '0);
      req_i = 1'b1;
      held = ref_of(idx);
      @(negedge clk);
      req_i = 1'b0;
      apply((idx * 5 + 3) % 4096, '0);
      @(negedge clk);
      @(negedge clk);
      check("R7 hold without request", tgt_o, held);
      check("R8 flag held", trap_o, (held != 0) ? 1 : 0);
    end

    // Specific corner cases
    apply(0, '0); cur_el_i = 2'd2; acc_ctl_i[17:16] = 2'd0; mon_trap_i[8] = 1'b1;
    #1 check("R1 field 0 no trap at EL2", comb_tgt_o, 0);
    cur_el_i = 2'd1; acc_ctl_i[17:16] = 2'd1; acc_ctl_i[21:20] = 2'd3;
    #1 check("R1 field 1 allows EL1", comb_tgt_o, 0);
    cur_el_i = 2'd0; secure_i = 1'b1; el3_aa64_i = 1'b0;
    #1 check("R2 secure non-64 redirect", comb_tgt_o, 3);
    el3_aa64_i = 1'b1;
    #1 check("R2 secure 64-bit stays EL1", comb_tgt_o, 1);
    acc_ctl_i[17:16] = 2'd3; secure_i = 1'b0; hyp_trap_i[10] = 1'b1; cur_el_i = 2'd2;
    #1 check("R4 EL2 FP trap bit", comb_tgt_o, 2);
    hyp_trap_i[10] = 1'b0; mon_trap_i[8] = 1'b0;
    #1 check("R5 EL3 enable clear", comb_tgt_o, 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule